// File: doc/BRIEF.md
# IO Translation Unit Register Bank

This block is the software-visible configuration store for an IO address-translation unit. A host reaches it over a plain 32-bit register bus. The bus has a read strobe, a write strobe, a word address and write data, and read data comes back combinationally in the same cycle as the read strobe. The bank holds these registers: a control word, a page-table base, two flush registers (whole TLB and single page), four per-slot bus configuration words and an arbitration-enable word. Every register keeps only the bits its write mask allows. Some registers always read back with a fixed constant field.

The bank also turns the three-bit window-size field of the control word into the start address of the translation window. The window always ends at the top of the 32-bit address space. The start address goes to the translation datapath together with the enable bit and the table base. A write to either flush register stores the whole word. For exactly one cycle it also raises a strobe to the rest of the unit, and the stored value is presented with it.

Top module: `xlat_regbank`

## Requirements
- R1: After reset the control word reads 0x04000000. Base, both flush words, all slot words and arbitration enable read 0. `win_start` is 0, `xlat_en` is 0 and both flush strobes are low.
- R2: A write to word address 0x000 (control) stores `(data & 0x0000001D) | 0x04000000`, and a later read returns that value.
- R3: A write to control sets `win_start` from data bits [4:2] on the next cycle. Codes 0 to 7 give 0xFF000000, 0xFE000000, 0xFC000000, 0xF8000000, 0xF0000000, 0xE0000000, 0xC0000000 and 0x80000000. `win_start` does not change without a control write.
- R4: `xlat_en` equals bit 0 of the last value written to control, and it changes only on a control write.
- R5: A write to word address 0x001 (table base) stores `data & 0x07FFFC00`. The stored value reads back and is driven on `tbl_base`.
- R6: Word addresses 0x404 to 0x407 are slot configuration words 0 to 3. Each one independently stores `data & 0x00010003`: bit 0 is bypass, bit 1 is the 8-byte burst flag and bit 16 is the bypass physical address bit 30.
- R7: A write to word address 0x800 (arbitration enable) stores `(data & 0x001F0000) | 0x00000008`.
- R8: A write to word address 0x005 (TLB flush) or 0x006 (page flush) stores all 32 bits. In the cycle after the write the matching strobe is high for exactly one cycle, and the matching value output carries the written word.
- R9: A read of any other word address returns 0. A write to such an address changes no register.
- R10: `bus_rdata` carries the addressed register in the same cycle that `bus_rd` is high, and it is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (12) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| xlat_en | output | 1 | Translation enable |
| win_start | output | 32 | Translation window start address |
| tbl_base | output | 32 | Page-table base |
| tlb_flush_stb | output | 1 | One-cycle TLB flush strobe |
| tlb_flush_val | output | 32 | Stored TLB flush word |
| pg_flush_stb | output | 1 | One-cycle page flush strobe |
| pg_flush_val | output | 32 | Stored page flush word |

## Verification
On every cycle the assertions check these properties:
- The constant version field of control is present and the bits outside its mask are clear.
- The table base stays inside its mask.
- `win_start` is always a top-aligned power-of-two window. It and the enable bit move only on a control write.
- A flush strobe appears only directly after a write to its own register.
- Unmapped and idle reads return zero.

Only the bench scenarios can show the exact masked values per register, the mapping from each of the eight window codes to its address, the independence of the four slot words, and that a write to an unmapped address leaves the other registers untouched.

// File: rtl/xlat_regs_pkg.sv
// Package: shared word type, register word offsets, write masks and
// constant fields of the translation-unit register bank.
// Assumes a 32-bit data bus and word (not byte) addressing.
package xlat_regs_pkg;

    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Word offsets (byte offset divided by four)
    localparam int unsigned OFF_CTRL  = 'h000;
    localparam int unsigned OFF_BASE  = 'h001;
    localparam int unsigned OFF_TLB   = 'h005;
    localparam int unsigned OFF_PG    = 'h006;
    localparam int unsigned OFF_SLOT0 = 'h404;
    localparam int unsigned OFF_ARB   = 'h800;

    // Write masks and forced fields
    localparam word_t CTRL_KEEP  = 32'h0000_001D;
    localparam word_t CTRL_FORCE = 32'h0400_0000;
    localparam word_t BASE_KEEP  = 32'h07FF_FC00;
    localparam word_t FULL_KEEP  = 32'hFFFF_FFFF;
    localparam word_t SLOT_KEEP  = 32'h0001_0003;
    localparam word_t ARB_KEEP   = 32'h001F_0000;
    localparam word_t ARB_FORCE  = 32'h0000_0008;
    localparam word_t NO_FORCE   = 32'h0000_0000;

    // Smallest window is 16 MB; each code step doubles it.
    localparam word_t MIN_WINDOW = 32'h0100_0000;

    // Start address of a window of size MIN_WINDOW << code ending at the top.
    function automatic word_t window_start(input logic [2:0] code);
        return ~((MIN_WINDOW << code) - word_t'(1));
    endfunction

endpackage

// File: rtl/xlat_addr_decode.sv
// Address decoder: turns a word address into one select line per register.
// Assumes ADDR_W is wide enough to hold the arbitration-enable offset.
module xlat_addr_decode
    import xlat_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 sel_ctrl,
    output logic                 sel_base,
    output logic                 sel_tlb,
    output logic                 sel_pg,
    output logic                 sel_arb,
    output logic [NUM_SLOTS-1:0] sel_slot
);

    // Fixed single-register selects
    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
        sel_base = (addr == ADDR_W'(OFF_BASE));
        sel_tlb  = (addr == ADDR_W'(OFF_TLB));
        sel_pg   = (addr == ADDR_W'(OFF_PG));
        sel_arb  = (addr == ADDR_W'(OFF_ARB));
    end

    // One select per slot configuration word
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_sel
        assign sel_slot[i] = (addr == ADDR_W'(OFF_SLOT0 + i));
    end

endmodule

// File: rtl/xlat_masked_reg.sv
// Masked register: on a write it stores (data & KEEP) | FORCE. Reset loads RST.
// Assumes the caller gates write enable with the address select.
module xlat_masked_reg
    import xlat_regs_pkg::*;
#(
    parameter word_t KEEP  = 32'hFFFF_FFFF,
    parameter word_t FORCE = 32'h0000_0000,
    parameter word_t RST   = 32'h0000_0000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  word_t wdata,
    output word_t q
);

    // Storage with per-register mask and forced field
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= (wdata & KEEP) | FORCE;
    end

endmodule

// File: rtl/xlat_window_decode.sv
// Window decoder: registers the window start address on each control write
// from the three-bit size code. Reset clears the start address to zero.
module xlat_window_decode
    import xlat_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] code,
    output word_t      start
);

    // Capture decoded start address on control write
    always_ff @(posedge clk) begin
        if (!rst_n)  start <= '0;
        else if (we) start <= window_start(code);
    end

endmodule

// File: rtl/xlat_flush_strobe.sv
// Flush strobe: a one-cycle pulse in the cycle after a flush write.
// Back-to-back writes give back-to-back pulses.
module xlat_flush_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    output logic stb
);

    // Delay the write strobe by one register
    always_ff @(posedge clk) begin
        if (!rst_n) stb <= 1'b0;
        else        stb <= we;
    end

endmodule

// File: rtl/xlat_regbank.sv
// Top: register bank of the IO translation unit. It decodes the address,
// holds the masked registers, derives the window start and flush strobes,
// and returns read data combinationally. Assumes one access per cycle;
// a read in the same cycle as a write returns the old value.
module xlat_regbank
    import xlat_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              xlat_en,
    output logic [31:0]       win_start,
    output logic [31:0]       tbl_base,
    output logic              tlb_flush_stb,
    output logic [31:0]       tlb_flush_val,
    output logic              pg_flush_stb,
    output logic [31:0]       pg_flush_val
);

    logic                 sel_ctrl, sel_base, sel_tlb, sel_pg, sel_arb;
    logic [NUM_SLOTS-1:0] sel_slot;
    word_t                ctrl_q, base_q, tlb_q, pg_q, arb_q;
    word_t                slot_q [NUM_SLOTS];

    xlat_addr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr     (bus_addr),
        .sel_ctrl (sel_ctrl),
        .sel_base (sel_base),
        .sel_tlb  (sel_tlb),
        .sel_pg   (sel_pg),
        .sel_arb  (sel_arb),
        .sel_slot (sel_slot)
    );

    xlat_masked_reg #(.KEEP(CTRL_KEEP), .FORCE(CTRL_FORCE), .RST(CTRL_FORCE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_ctrl), .wdata(bus_wdata), .q(ctrl_q)
    );

    xlat_masked_reg #(.KEEP(BASE_KEEP), .FORCE(NO_FORCE), .RST('0)) u_base (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_base), .wdata(bus_wdata), .q(base_q)
    );

    xlat_masked_reg #(.KEEP(FULL_KEEP), .FORCE(NO_FORCE), .RST('0)) u_tlb (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_tlb), .wdata(bus_wdata), .q(tlb_q)
    );

    xlat_masked_reg #(.KEEP(FULL_KEEP), .FORCE(NO_FORCE), .RST('0)) u_pg (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_pg), .wdata(bus_wdata), .q(pg_q)
    );

    xlat_masked_reg #(.KEEP(ARB_KEEP), .FORCE(ARB_FORCE), .RST('0)) u_arb (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_arb), .wdata(bus_wdata), .q(arb_q)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        xlat_masked_reg #(.KEEP(SLOT_KEEP), .FORCE(NO_FORCE), .RST('0)) u_slot (
            .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_slot[i]),
            .wdata(bus_wdata), .q(slot_q[i])
        );
    end

    xlat_window_decode u_win (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_ctrl),
        .code(bus_wdata[4:2]), .start(win_start)
    );

    xlat_flush_strobe u_tlb_stb (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_tlb), .stb(tlb_flush_stb)
    );

    xlat_flush_strobe u_pg_stb (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_pg), .stb(pg_flush_stb)
    );

    // Exported configuration
    assign xlat_en       = ctrl_q[0];
    assign tbl_base      = base_q;
    assign tlb_flush_val = tlb_q;
    assign pg_flush_val  = pg_q;

    // Same-cycle read multiplexer; zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl) bus_rdata = ctrl_q;
            if (sel_base) bus_rdata = base_q;
            if (sel_tlb)  bus_rdata = tlb_q;
            if (sel_pg)   bus_rdata = pg_q;
            if (sel_arb)  bus_rdata = arb_q;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (sel_slot[i]) bus_rdata = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/xlat_regbank_chk.sv
// Checker: cycle-by-cycle properties of the register bank, attached by bind.
// Looks only at the top-level ports.
module xlat_regbank_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              xlat_en,
    input logic [31:0]       win_start,
    input logic [31:0]       tbl_base,
    input logic              tlb_flush_stb,
    input logic              pg_flush_stb
);

    logic ctrl_wr, tlb_wr, pg_wr, mapped;

    // Independent view of which accesses hit which register
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));
        tlb_wr  = bus_wr && (bus_addr == ADDR_W'(5));
        pg_wr   = bus_wr && (bus_addr == ADDR_W'(6));
        mapped  = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(1)) ||
                  (bus_addr == ADDR_W'(5)) || (bus_addr == ADDR_W'(6)) ||
                  (bus_addr == ADDR_W'('h800)) ||
                  ((bus_addr >= ADDR_W'('h404)) && (bus_addr < ADDR_W'('h404 + NUM_SLOTS)));
    end

    p_ctrl_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |->
            (bus_rdata[31:24] == 8'h04) && ((bus_rdata & 32'hFBFF_FFE2) == 32'h0));

    p_window_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~win_start + 32'd1) && (win_start[23:0] == 24'h0));

    p_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(win_start));

    p_window_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> win_start[31]);

    p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(xlat_en));

    p_base_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_base & 32'hF800_03FF) == 32'h0);

    p_tlb_stb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr |=> tlb_flush_stb);

    p_pg_stb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr |=> pg_flush_stb);

    p_stb_only_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlb_wr || pg_wr) |=> !(tlb_flush_stb || pg_flush_stb) || $past(tlb_wr || pg_wr));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> (bus_rdata == 32'h0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 32'h0));

endmodule

bind xlat_regbank xlat_regbank_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .xlat_en(xlat_en), .win_start(win_start),
    .tbl_base(tbl_base), .tlb_flush_stb(tlb_flush_stb), .pg_flush_stb(pg_flush_stb)
);

// File: tb/test_xlat_regbank.sv
// Bench: a table of write/read-back vectors, then directed tests for reset,
// window codes, enable, flush strobes and unmapped addresses.
module test_xlat_regbank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, win_start, tbl_base, tlb_flush_val, pg_flush_val;
    logic        xlat_en, tlb_flush_stb, pg_flush_stb;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_regbank i_xlat_regbank (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xlat_en(xlat_en), .win_start(win_start), .tbl_base(tbl_base),
        .tlb_flush_stb(tlb_flush_stb), .tlb_flush_val(tlb_flush_val),
        .pg_flush_stb(pg_flush_stb), .pg_flush_val(pg_flush_val)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] expd;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{12'h000, 32'hFFFF_FFFF, 32'h0400_001D, 4'd2},  // R2
        '{12'h000, 32'h0000_0000, 32'h0400_0000, 4'd2},  // R2
        '{12'h001, 32'hFFFF_FFFF, 32'h07FF_FC00, 4'd5},  // R5
        '{12'h001, 32'h1234_5678, 32'h0234_5400, 4'd5},  // R5
        '{12'h005, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd8},  // R8
        '{12'h006, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd8},  // R8
        '{12'h404, 32'hFFFF_FFFF, 32'h0001_0003, 4'd6},  // R6
        '{12'h405, 32'h0000_0006, 32'h0000_0002, 4'd6},  // R6
        '{12'h406, 32'h0001_0000, 32'h0001_0000, 4'd6},  // R6
        '{12'h407, 32'hFFFE_FFFC, 32'h0000_0000, 4'd6},  // R6
        '{12'h800, 32'hFFFF_FFFF, 32'h001F_0008, 4'd7},  // R7
        '{12'h800, 32'h0000_0000, 32'h0000_0008, 4'd7},  // R7
        '{12'h002, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9},  // R9
        '{12'h7FF, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9}   // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] exp_window(input int code);
        return 32'hFFFF_FFFF << (24 + code);
    endfunction

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(12'h000, rd); check("R1 ctrl", rd, 32'h0400_0000);
        bus_read(12'h001, rd); check("R1 base", rd, 32'h0);
        bus_read(12'h800, rd); check("R1 arb", rd, 32'h0);
        bus_read(12'h405, rd); check("R1 slot1", rd, 32'h0);
        check("R1 win_start", win_start, 32'h0);
        check("R1 xlat_en", {31'h0, xlat_en}, 32'h0);
        check("R1 strobes", {30'h0, tlb_flush_stb, pg_flush_stb}, 32'h0);

        // R10: idle read data is zero
        check("R10 idle rdata", bus_rdata, 32'h0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, rd);
            checks++;
            if (rd !== VECS[i].expd) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[i].req, i, rd, VECS[i].expd);
            end
        end

        // R9: unmapped writes left every register alone
        bus_read(12'h001, rd); check("R9 base kept", rd, 32'h0234_5400);
        bus_read(12'h005, rd); check("R9 tlb kept", rd, 32'hDEAD_BEEF);
        // R6: slot words independent
        bus_read(12'h404, rd); check("R6 slot0 kept", rd, 32'h0001_0003);
        bus_read(12'h406, rd); check("R6 slot2 kept", rd, 32'h0001_0000);
        // R5: base export
        check("R5 tbl_base port", tbl_base, 32'h0234_5400);

        // R3, R4: each window code with enable set, then cleared
        for (int c = 0; c < 8; c++) begin
            bus_write(12'h000, (c << 2) | 1);
            check($sformatf("R3 code %0d", c), win_start, exp_window(c));
            check("R4 enable on", {31'h0, xlat_en}, 32'h1);
        end
        bus_write(12'h000, 32'h0000_0008);
        check("R3 code 2 no enable", win_start, 32'hFC00_0000);
        check("R4 enable off", {31'h0, xlat_en}, 32'h0);
        // R3: non-control write keeps window
        bus_write(12'h001, 32'h0);
        check("R3 window held", win_start, 32'hFC00_0000);

        // R8: TLB flush strobe exactly one cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h005; bus_wdata = 32'h1357_9BDF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 tlb stb high", {31'h0, tlb_flush_stb}, 32'h1);
        check("R8 tlb val", tlb_flush_val, 32'h1357_9BDF);
        check("R8 pg stb quiet", {31'h0, pg_flush_stb}, 32'h0);
        @(negedge clk);
        check("R8 tlb stb one cycle", {31'h0, tlb_flush_stb}, 32'h0);

        // R8: page flush strobe
        bus_wr = 1'b1; bus_addr = 12'h006; bus_wdata = 32'h0000_F000;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 pg stb high", {31'h0, pg_flush_stb}, 32'h1);
        check("R8 pg val", pg_flush_val, 32'h0000_F000);
        @(negedge clk);
        check("R8 pg stb one cycle", {31'h0, pg_flush_stb}, 32'h0);

        // R10: same-cycle read
        bus_rd = 1'b1; bus_addr = 12'h006;
        #1;
        check("R10 same cycle read", bus_rdata, 32'h0000_F000);
        bus_rd = 1'b0;
        #1;
        check("R10 rdata drops", bus_rdata, 32'h0);

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(12'h000, rd); check("R1 ctrl after reset", rd, 32'h0400_0000);
        bus_read(12'h006, rd); check("R1 pg after reset", rd, 32'h0);
        check("R1 window after reset", win_start, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule